// File: doc/BRIEF.md
# Sub-Dword Operand Select Unit

This stage wraps a 32-bit per-lane ALU operation so that each source operand can be narrowed to one byte or one half-word before the operation. Each narrowed operand is widened back to 32 bits with either zero fill or sign fill. The operation result is then written back into a chosen byte, half-word or the whole word of the destination register. Up to two sources are handled. When the instruction has only one source, the second source is not used and the operation passes the converted first source through.

Each cycle the block samples a complete operand set: src0, src1, the old destination value, the select codes, the sign flags, the opcode, the destination select and the fill mode. On the next rising clock edge it registers the new destination word. Instruction decode and the register file live outside the block.

Top module: `sdsel_unit`

## Requirements
- R1: Source select codes are 3 bits. Codes 0, 1, 2 and 3 take byte n, which is bits [8n+7:8n]. Code 4 takes bits [15:0] and code 5 takes bits [31:16]. With the sign flag clear, the bits above the selected field are zero.
- R2: With a source's sign flag set, a selected byte is widened from bit 7 and a selected half-word from bit 15, by copying that bit into every higher bit.
- R3: Source code 6 passes the whole 32-bit operand unchanged, and the sign flag has no effect on it. Code 7 behaves as code 6.
- R4: When has_src1 is 0, the operation result equals the converted src0, for every opcode. src1, sel1 and sext1 then have no effect on the output.
- R5: When has_src1 is 1, the opcode acts on the two converted operands: 0 gives XOR, 1 gives ADD modulo 2^32, 2 gives AND, and 3 behaves as XOR.
- R6: Destination code 6 or 7 writes the full 32-bit result, and the old destination value has no effect.
- R7: Destination codes 0 to 5 use the same field positions as the source codes. The low 8 bits of the result (for a byte field) or the low 16 bits (for a half-word field) are placed in that field.
- R8: Fill mode 0 clears every destination bit outside the selected field.
- R9: Fill mode 1 copies the top bit of the placed field into every bit above the field and clears the bits below it.
- R10: Fill modes 2 and 3 keep the old destination bits outside the selected field.
- R11: dst_out is a register. It shows the result for the inputs sampled at a rising clock edge from just after that edge. A synchronous active-low reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src0 | input | 32 | First source operand |
| src1 | input | 32 | Second source operand |
| dst_old | input | 32 | Destination register value before the operation |
| sel0 | input | 3 | Field select for src0 |
| sel1 | input | 3 | Field select for src1 |
| sext0 | input | 1 | Sign-fill flag for src0 |
| sext1 | input | 1 | Sign-fill flag for src1 |
| has_src1 | input | 1 | The instruction uses a second source |
| opcode | input | 2 | Operation select |
| dst_sel | input | 3 | Destination field select |
| fill_mode | input | 2 | Handling of destination bits outside the field |
| dst_out | output | 32 | New destination value, registered |

## Verification
A sweep drives every combination of source select, sign flag, destination select and fill mode, with random operands, a random opcode and a random has_src1. Because the operands are random, a wrong lane, a wrong sign source or a misplaced field shows up as a value mismatch, not only as a zero/non-zero difference. Directed cases use operands whose selected byte or half-word has its top bit set, so that zero fill and sign fill give different values. They also pair has_src1 low with several different src1 values, which exposes any leak of the second source. ADD with a carry out of bit 31, and AND against XOR on narrowed operands, separate the opcodes and show that the operation works on converted operands and not raw ones.

// File: rtl/sdsel_pkg.sv
// Shared encodings for the sub-dword operand select unit.
// Assumes a 32-bit lane split into four bytes and two half-words.
package sdsel_pkg;
    localparam int DATA_W = 32;
    localparam int SEL_W  = 3;
    localparam int OP_W   = 2;
    localparam int MODE_W = 2;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int NUM_BYTES = DATA_W / BYTE_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_B0   = 3'd0,
        SEL_B1   = 3'd1,
        SEL_B2   = 3'd2,
        SEL_B3   = 3'd3,
        SEL_H0   = 3'd4,
        SEL_H1   = 3'd5,
        SEL_FULL = 3'd6
    } field_sel_e;

    typedef enum logic [OP_W-1:0] {
        OP_XOR = 2'd0,
        OP_ADD = 2'd1,
        OP_AND = 2'd2,
        OP_ALT = 2'd3
    } alu_op_e;

    typedef enum logic [MODE_W-1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_KEEP = 2'd2,
        FILL_ALT  = 2'd3
    } fill_mode_e;
endpackage

// File: rtl/sdsel_extract.sv
// Narrows one source operand to a byte, a half-word or the full word and
// widens it back to the lane width with zero or sign fill.
// Assumes the select encoding from sdsel_pkg; codes above SEL_FULL act as full.
module sdsel_extract
    import sdsel_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]     raw,
    input  logic [SEL_W-1:0] sel,
    input  logic             sext,
    output logic [W-1:0]     wide
);
    localparam int NB = W / BYTE_W;
    localparam int NH = W / HALF_W;

    logic [BYTE_W-1:0] byte_lane [NB];
    logic [HALF_W-1:0] half_lane [NH];

    genvar gb, gh;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_byte
            assign byte_lane[gb] = raw[gb*BYTE_W +: BYTE_W];
        end
        for (gh = 0; gh < NH; gh++) begin : g_half
            assign half_lane[gh] = raw[gh*HALF_W +: HALF_W];
        end
    endgenerate

    logic [BYTE_W-1:0] pick_b;
    logic [HALF_W-1:0] pick_h;

    // Choose the lane and widen it according to the sign flag.
    always_comb begin
        pick_b = byte_lane[sel[1:0]];
        pick_h = half_lane[sel[0]];
        if (sel <= SEL_B3) begin
            wide = {{(W-BYTE_W){sext & pick_b[BYTE_W-1]}}, pick_b};
        end else if (sel <= SEL_H1) begin
            wide = {{(W-HALF_W){sext & pick_h[HALF_W-1]}}, pick_h};
        end else begin
            wide = raw;
        end
    end
endmodule

// File: rtl/sdsel_alu.sv
// Simple lane operation on the converted operands.
// Assumes a single-source instruction just forwards operand a.
module sdsel_alu
    import sdsel_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    input  logic            has_b,
    output logic [W-1:0]    y
);
    // Apply the chosen operation, or forward a when there is no second source.
    always_comb begin
        if (!has_b) begin
            y = a;
        end else begin
            unique case (op)
                OP_ADD:  y = a + b;
                OP_AND:  y = a & b;
                default: y = a ^ b;
            endcase
        end
    end
endmodule

// File: rtl/sdsel_merge.sv
// Places the operation result into the chosen destination field and fills
// the remaining bits from zero, the field's top bit, or the old value.
// Assumes fields are whole bytes; codes above SEL_FULL act as full.
module sdsel_merge
    import sdsel_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      res,
    input  logic [W-1:0]      old,
    input  logic [SEL_W-1:0]  sel,
    input  logic [MODE_W-1:0] mode,
    output logic [W-1:0]      merged
);
    localparam int NB  = W / BYTE_W;
    localparam int IXW = $clog2(NB) + 1;

    logic [IXW-1:0] lo_byte;
    logic [IXW-1:0] hi_byte;
    logic           field_sign;

    // Decode the field as a range of whole bytes [lo_byte, hi_byte).
    always_comb begin
        if (sel <= SEL_B3) begin
            lo_byte    = IXW'(sel[1:0]);
            hi_byte    = IXW'(sel[1:0]) + IXW'(1);
            field_sign = res[BYTE_W-1];
        end else if (sel <= SEL_H1) begin
            lo_byte    = sel[0] ? IXW'(2) : IXW'(0);
            hi_byte    = sel[0] ? IXW'(4) : IXW'(2);
            field_sign = res[HALF_W-1];
        end else begin
            lo_byte    = '0;
            hi_byte    = IXW'(NB);
            field_sign = 1'b0;
        end
    end

    genvar gk;
    generate
        for (gk = 0; gk < NB; gk++) begin : g_out_byte
            logic [IXW-1:0] rel;
            assign rel = IXW'(gk) - lo_byte;
            // Pick the source for output byte gk from its place relative to the field.
            always_comb begin
                if (IXW'(gk) >= lo_byte && IXW'(gk) < hi_byte) begin
                    merged[gk*BYTE_W +: BYTE_W] = res[rel[IXW-2:0]*BYTE_W +: BYTE_W];
                end else if (mode[1]) begin
                    merged[gk*BYTE_W +: BYTE_W] = old[gk*BYTE_W +: BYTE_W];
                end else if (mode[0] && IXW'(gk) >= hi_byte) begin
                    merged[gk*BYTE_W +: BYTE_W] = {BYTE_W{field_sign}};
                end else begin
                    merged[gk*BYTE_W +: BYTE_W] = '0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sdsel_unit.sv
// Top of the sub-dword operand select unit: converts both sources, runs the
// lane operation, merges into the destination field and registers the word.
// Assumes all inputs are valid every cycle; latency is one clock.
module sdsel_unit
    import sdsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src0,
    input  logic [31:0]       src1,
    input  logic [31:0]       dst_old,
    input  logic [2:0]        sel0,
    input  logic [2:0]        sel1,
    input  logic              sext0,
    input  logic              sext1,
    input  logic              has_src1,
    input  logic [1:0]        opcode,
    input  logic [2:0]        dst_sel,
    input  logic [1:0]        fill_mode,
    output logic [31:0]       dst_out
);
    logic [DATA_W-1:0] opnd0, opnd1, alu_y, merged;

    sdsel_extract #(.W(DATA_W)) u_ext0 (
        .raw (src0), .sel (sel0), .sext (sext0), .wide (opnd0)
    );

    sdsel_extract #(.W(DATA_W)) u_ext1 (
        .raw (src1), .sel (sel1), .sext (sext1), .wide (opnd1)
    );

    sdsel_alu #(.W(DATA_W)) u_alu (
        .a (opnd0), .b (opnd1), .op (opcode), .has_b (has_src1), .y (alu_y)
    );

    sdsel_merge #(.W(DATA_W)) u_merge (
        .res (alu_y), .old (dst_old), .sel (dst_sel), .mode (fill_mode),
        .merged (merged)
    );

    // Register the merged destination word; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_out <= '0;
        end else begin
            dst_out <= merged;
        end
    end
endmodule

// File: rtl/sdsel_unit_chk.sv
// Port-level properties of sdsel_unit, attached through bind.
// Assumes one-clock latency from inputs to dst_out.
module sdsel_unit_chk
    import sdsel_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] src0,
    input logic [2:0]  sel0,
    input logic        sext0,
    input logic        has_src1,
    input logic [31:0] dst_old,
    input logic [2:0]  dst_sel,
    input logic [1:0]  fill_mode,
    input logic [31:0] dst_out
);
    logic full_path;
    assign full_path = !has_src1 && dst_sel >= SEL_FULL;

    AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (full_path && sel0 == SEL_B0 && !sext0)
        |=> (dst_out == {24'h0, $past(src0[7:0])})); // R1

    AST_HALF_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (full_path && sel0 == SEL_H1 && sext0)
        |=> (dst_out == {{16{$past(src0[31])}}, $past(src0[31:16])})); // R2

    AST_FULL_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (full_path && sel0 >= SEL_FULL)
        |=> (dst_out == $past(src0))); // R3

    AST_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == SEL_H0 && fill_mode == FILL_ZERO)
        |=> (dst_out[31:16] == 16'h0)); // R8

    AST_SIGN_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == SEL_B1 && fill_mode == FILL_SIGN)
        |=> (dst_out[31:16] == {16{dst_out[15]}} && dst_out[7:0] == 8'h0)); // R9

    AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_sel == SEL_B0 && fill_mode[1])
        |=> (dst_out[31:8] == $past(dst_old[31:8]))); // R10
endmodule

bind sdsel_unit sdsel_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src0      (src0),
    .sel0      (sel0),
    .sext0     (sext0),
    .has_src1  (has_src1),
    .dst_old   (dst_old),
    .dst_sel   (dst_sel),
    .fill_mode (fill_mode),
    .dst_out   (dst_out)
);

// File: tb/sdsel_unit_tb_top.sv
// Scoreboard bench: the driver pushes expected words, the monitor pops and
// compares them one clock later.
module sdsel_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src0 = '0, src1 = '0, dst_old = '0;
    logic [2:0]  sel0 = '0, sel1 = '0, dst_sel = '0;
    logic        sext0 = 1'b0, sext1 = 1'b0, has_src1 = 1'b0;
    logic [1:0]  opcode = '0, fill_mode = '0;
    logic [31:0] dst_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    sdsel_unit dut_i (
        .clk (clk), .rst_n (rst_n), .src0 (src0), .src1 (src1),
        .dst_old (dst_old), .sel0 (sel0), .sel1 (sel1), .sext0 (sext0),
        .sext1 (sext1), .has_src1 (has_src1), .opcode (opcode),
        .dst_sel (dst_sel), .fill_mode (fill_mode), .dst_out (dst_out)
    );

    // Behavioural conversion of one source operand.
    function automatic logic [31:0] ref_conv(logic [31:0] v, logic [2:0] s, logic sx);
        logic [31:0] r;
        if (s < 4) begin
            r = (v >> (8 * s)) & 32'hFF;
            if (sx && r[7]) r = r | 32'hFFFF_FF00;
        end else if (s < 6) begin
            r = (v >> (16 * (s - 4))) & 32'hFFFF;
            if (sx && r[15]) r = r | 32'hFFFF_0000;
        end else begin
            r = v;
        end
        return r;
    endfunction

    // Behavioural model of the whole unit.
    function automatic logic [31:0] ref_model(
        logic [31:0] a, logic [31:0] b, logic [31:0] old, logic [2:0] s0,
        logic [2:0] s1, logic x0, logic x1, logic hb, logic [1:0] op,
        logic [2:0] ds, logic [1:0] fm);
        logic [31:0] ca, cb, res;
        logic [63:0] fmask, field, upper;
        int w, pos;
        ca = ref_conv(a, s0, x0);
        cb = ref_conv(b, s1, x1);
        if (!hb) res = ca;
        else if (op == 2'd1) res = ca + cb;
        else if (op == 2'd2) res = ca & cb;
        else res = ca ^ cb;
        if (ds >= 6) return res;
        w     = (ds < 4) ? 8 : 16;
        pos   = (ds < 4) ? 8 * ds : 16 * (ds - 4);
        fmask = ((64'd1 << w) - 1) << pos;
        field = ({32'h0, res} & ((64'd1 << w) - 1)) << pos;
        upper = ~((64'd1 << (pos + w)) - 1);
        if (fm == 2'd0) return field[31:0];
        if (fm == 2'd1) return field[31:0] | (res[w-1] ? upper[31:0] : 32'h0);
        return field[31:0] | (old & ~fmask[31:0]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: apply one operand set at the falling edge and queue its result.
    task automatic drive(string tag, logic [31:0] a, logic [31:0] b,
                         logic [31:0] old, logic [2:0] s0, logic [2:0] s1,
                         logic x0, logic x1, logic hb, logic [1:0] op,
                         logic [2:0] ds, logic [1:0] fm, logic [31:0] fixed,
                         bit use_fixed);
        logic [31:0] e;
        @(negedge clk);
        src0 = a; src1 = b; dst_old = old; sel0 = s0; sel1 = s1;
        sext0 = x0; sext1 = x1; has_src1 = hb; opcode = op;
        dst_sel = ds; fill_mode = fm;
        e = ref_model(a, b, old, s0, s1, x0, x1, hb, op, ds, fm);
        if (use_fixed) check({tag, " model"}, e, fixed);
        exp_q.push_back(use_fixed ? fixed : e);
        tag_q.push_back(tag);
    endtask

    // Monitor: one clock after the driver, compare the registered word.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), dst_out, exp_q.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string t;
        repeat (3) @(negedge clk);
        check("R11 reset", dst_out, 32'h0);
        rst_n = 1'b1;

        // R1: byte 2, zero fill.
        drive("R1", 32'h1122_3344, 32'h0, 32'h0, 3'd2, 3'd0, 1'b0, 1'b0, 1'b0,
              2'd0, 3'd6, 2'd0, 32'h0000_0022, 1'b1);
        // R2: byte sign fill and half-word sign fill.
        drive("R2", 32'h00F0_0000, 32'h0, 32'h0, 3'd2, 3'd0, 1'b1, 1'b0, 1'b0,
              2'd0, 3'd6, 2'd0, 32'hFFFF_FFF0, 1'b1);
        drive("R2", 32'h8001_1234, 32'h0, 32'h0, 3'd5, 3'd0, 1'b1, 1'b0, 1'b0,
              2'd0, 3'd6, 2'd0, 32'hFFFF_8001, 1'b1);
        // R3: full word ignores sign flag; code 7 acts as full.
        drive("R3", 32'h89AB_CDEF, 32'h0, 32'h0, 3'd6, 3'd0, 1'b1, 1'b0, 1'b0,
              2'd0, 3'd6, 2'd0, 32'h89AB_CDEF, 1'b1);
        drive("R3", 32'h89AB_CDEF, 32'h0, 32'h0, 3'd7, 3'd0, 1'b1, 1'b0, 1'b0,
              2'd0, 3'd7, 2'd0, 32'h89AB_CDEF, 1'b1);
        // R4: second source ignored without has_src1.
        drive("R4", 32'h0000_00C3, 32'h0000_0000, 32'h0, 3'd0, 3'd6, 1'b0, 1'b0,
              1'b0, 2'd2, 3'd6, 2'd0, 32'h0000_00C3, 1'b1);
        drive("R4", 32'h0000_00C3, 32'hFFFF_FFFF, 32'h0, 3'd0, 3'd1, 1'b0, 1'b1,
              1'b0, 2'd1, 3'd6, 2'd0, 32'h0000_00C3, 1'b1);
        // R5: ADD wrap, AND and XOR on narrowed operands.
        drive("R5", 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 3'd6, 3'd6, 1'b0, 1'b0,
              1'b1, 2'd1, 3'd6, 2'd0, 32'h0000_0000, 1'b1);
        drive("R5", 32'hAB00_00F0, 32'hCD00_3C00, 32'h0, 3'd0, 3'd1, 1'b0, 1'b0,
              1'b1, 2'd2, 3'd6, 2'd0, 32'h0000_0030, 1'b1);
        drive("R5", 32'hAB00_00F0, 32'hCD00_3C00, 32'h0, 3'd0, 3'd1, 1'b0, 1'b0,
              1'b1, 2'd3, 3'd6, 2'd0, 32'h0000_00CC, 1'b1);
        // R6: full destination ignores old value.
        drive("R6", 32'h1357_9BDF, 32'h0, 32'hFFFF_FFFF, 3'd6, 3'd0, 1'b0, 1'b0,
              1'b0, 2'd0, 3'd6, 2'd2, 32'h1357_9BDF, 1'b1);
        // R7 and R9: byte 1 placement with sign fill upward.
        drive("R7 R9", 32'h0000_00A5, 32'h0, 32'h1234_5678, 3'd0, 3'd0, 1'b0, 1'b0,
              1'b0, 2'd0, 3'd1, 2'd1, 32'hFFFF_A500, 1'b1);
        // R8: zero fill outside the upper half-word.
        drive("R8", 32'h0000_BEEF, 32'h0, 32'h1234_5678, 3'd4, 3'd0, 1'b0, 1'b0,
              1'b0, 2'd0, 3'd5, 2'd0, 32'hBEEF_0000, 1'b1);
        // R10: keep old bits, modes 2 and 3.
        drive("R10", 32'h0000_BEEF, 32'h0, 32'h1234_5678, 3'd4, 3'd0, 1'b0, 1'b0,
              1'b0, 2'd0, 3'd5, 2'd2, 32'hBEEF_5678, 1'b1);
        drive("R10", 32'h0000_BEEF, 32'h0, 32'h1234_5678, 3'd4, 3'd0, 1'b0, 1'b0,
              1'b0, 2'd0, 3'd5, 2'd3, 32'hBEEF_5678, 1'b1);

        // Sweep every select, sign flag, destination and fill mode combination.
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 2; x++) begin
                for (int d = 0; d < 8; d++) begin
                    for (int m = 0; m < 4; m++) begin
                        if (d >= 6)      t = "R6 sweep";
                        else if (m == 0) t = "R8 sweep";
                        else if (m == 1) t = "R9 sweep";
                        else             t = "R10 sweep";
                        drive(t, $urandom(), $urandom(), $urandom(), 3'(s),
                              3'($urandom_range(0, 7)), x[0], 1'($urandom()),
                              1'($urandom()), 2'($urandom()), 3'(d), 2'(m),
                              32'h0, 1'b0);
                    end
                end
            end
        end

        repeat (3) @(negedge clk);
        check("R11 drained", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule